// File: doc/BRIEF.md
# Trigger Busy Generator

This block produces the busy level that tells the trigger system to hold off further L0 triggers. Each L0 trigger pulse arms a hold timer. The timer keeps busy high for a number of clock cycles that the host programs. Busy also stays high for as long as every front-end buffer is assumed to be in use. The block keeps an estimate of buffer occupancy for this purpose. It adds one for each trigger and subtracts one for each event that the matching controller reports as retired. The result is compared against a buffer count that the host configures.

A 32-bit accumulator counts every cycle in which busy is high. The host reads it as two 16-bit halves. A read of the low half captures the upper half at the same moment, so the two reads together form one consistent value. The host reaches the hold length, the buffer count and the accumulator through a small word-addressed register port.

Top module: `trig_busy_gen`

## Requirements
- R1: The clock edge that samples `l0_trig_i` high loads the hold timer with the programmed hold length N. `busy_o` is then high for the N cycles that follow that edge. When N is 0, the timer adds no busy cycles.
- R2: A trigger that arrives while the timer is running reloads the timer to the full current hold length.
- R3: The occupancy estimate changes by +1 on a trigger alone and by -1 on a retirement alone. It stays unchanged when both arrive in the same cycle. It never rises on a trigger while it is at or above the buffer count, and it never falls below 0.
- R4: `busy_o` is high whenever the occupancy is at or above the configured buffer count, whatever state the timer is in. A buffer count of 0 therefore holds busy high permanently.
- R5: The register at address 0 is the hold length (16 bits, read/write, reset value `DEF_HOLD`). The register at address 1 is the buffer count (16 bits, read/write, reset value `DEF_BUFS`). A write takes effect at the clock edge where `reg_wr_en_i` is sampled. `reg_rdata_o` reflects the current `reg_addr_i` combinationally.
- R6: The busy-time accumulator starts from 0 after reset. At each clock edge where `busy_o` was high it increments by one, wrapping modulo 2^32. At all other edges it holds its value.
- R7: Address 3 returns bits 15:0 of the accumulator as they are now. At an edge where `reg_rd_en_i` is high with address 3, bits 31:16 are captured. Address 2 returns the most recently captured upper half, or 0 after reset.
- R8: After reset, `busy_o` is low as long as `DEF_BUFS` is nonzero. The occupancy starts at 0 and the timer starts idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l0_trig_i | input | 1 | L0 trigger pulse, one cycle per trigger |
| evt_retire_i | input | 1 | Event retired by the matching controller |
| busy_o | output | 1 | Busy level to the trigger system |
| reg_wr_en_i | input | 1 | Host register write strobe |
| reg_rd_en_i | input | 1 | Host register read strobe |
| reg_addr_i | input | 2 | Host register address |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Host read data, combinational on address |

## Verification
The bench retriggers midway through a hold. A design that let the first timeout run to its end instead of reloading would drop busy early. It pushes more triggers than there are buffers and then retires one. A counter that did not saturate would keep busy stuck high. It issues retirements into an empty occupancy and then checks that busy asserts exactly when the count comes back to full. An underflowing counter would wrap and hold busy high. It also sends a trigger and a retirement in the same cycle. It runs the accumulator past 2^16 and reads the halves far apart in time. An upper half that was read live instead of captured would return a newer value. Hold lengths and buffer counts of zero are also covered.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
    localparam int HOST_W  = 16;
    localparam int HOLD_W  = 16;
    localparam int BUF_W   = 16;
    localparam int BTIME_W = 32;
    localparam int HALF_W  = BTIME_W / 2;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_HOLD  = 2'd0,
        REG_BUFS  = 2'd1,
        REG_BT_HI = 2'd2,
        REG_BT_LO = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic [BUF_W-1:0]  bufs;
    } tbg_cfg_t;

    typedef struct packed {
        logic trig;
        logic retire;
    } tbg_evt_t;

    // Next occupancy: simultaneous trigger and retire cancel; saturate at 0 and at limit.
    function automatic logic [BUF_W-1:0] occ_next(
        input logic [BUF_W-1:0] occ,
        input logic [BUF_W-1:0] limit,
        input tbg_evt_t         evt
    );
        logic [BUF_W-1:0] res;
        res = occ;
        if (evt.trig && !evt.retire && (occ < limit))
            res = occ + BUF_W'(1);
        else if (evt.retire && !evt.trig && (occ != '0))
            res = occ - BUF_W'(1);
        return res;
    endfunction
endpackage

// File: rtl/tbg_regs.sv
module tbg_regs
    import tbg_pkg::*;
#(
    parameter logic [HOLD_W-1:0] DEF_HOLD = HOLD_W'(8),
    parameter logic [BUF_W-1:0]  DEF_BUFS = BUF_W'(4)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [HOST_W-1:0]  wdata,
    input  logic [BTIME_W-1:0] btime,
    output tbg_cfg_t           cfg,
    output logic [HOST_W-1:0]  rdata
);
    reg_addr_e         sel;
    logic [HALF_W-1:0] hi_snap_q;

    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.hold  <= DEF_HOLD;
            cfg.bufs  <= DEF_BUFS;
            hi_snap_q <= '0;
        end else begin
            if (wr_en && sel == REG_HOLD) cfg.hold <= HOLD_W'(wdata);
            if (wr_en && sel == REG_BUFS) cfg.bufs <= BUF_W'(wdata);
            if (rd_en && sel == REG_BT_LO)
                hi_snap_q <= btime[BTIME_W-1 -: HALF_W];
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            REG_HOLD:  rdata = HOST_W'(cfg.hold);
            REG_BUFS:  rdata = HOST_W'(cfg.bufs);
            REG_BT_HI: rdata = HOST_W'(hi_snap_q);
            REG_BT_LO: rdata = HOST_W'(btime[HALF_W-1:0]);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/tbg_hold_timer.sv
module tbg_hold_timer
    import tbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [HOLD_W-1:0] hold,
    output logic [HOLD_W-1:0] timer_q,
    output logic              active
);
    always_ff @(posedge clk) begin
        if (rst)
            timer_q <= '0;
        else if (trig)
            timer_q <= hold;
        else if (timer_q != '0)
            timer_q <= timer_q - HOLD_W'(1);
    end

    assign active = (timer_q != '0);
endmodule

// File: rtl/tbg_occupancy.sv
module tbg_occupancy
    import tbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tbg_evt_t         evt,
    input  logic [BUF_W-1:0] limit,
    output logic [BUF_W-1:0] occ_q,
    output logic             full
);
    always_ff @(posedge clk) begin
        if (rst) occ_q <= '0;
        else     occ_q <= occ_next(occ_q, limit, evt);
    end

    assign full = (occ_q >= limit);
endmodule

// File: rtl/tbg_busy_accum.sv
module tbg_busy_accum
    import tbg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               busy,
    output logic [BTIME_W-1:0] btime_q
);
    always_ff @(posedge clk) begin
        if (rst)       btime_q <= '0;
        else if (busy) btime_q <= btime_q + BTIME_W'(1);
    end
endmodule

// File: rtl/trig_busy_gen.sv
module trig_busy_gen
    import tbg_pkg::*;
#(
    parameter logic [HOLD_W-1:0] DEF_HOLD = HOLD_W'(8),
    parameter logic [BUF_W-1:0]  DEF_BUFS = BUF_W'(4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l0_trig_i,
    input  logic              evt_retire_i,
    output logic              busy_o,
    input  logic              reg_wr_en_i,
    input  logic              reg_rd_en_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [HOST_W-1:0] reg_wdata_i,
    output logic [HOST_W-1:0] reg_rdata_o
);
    tbg_cfg_t           cfg;
    tbg_evt_t           evt;
    logic [HOLD_W-1:0]  timer_q;
    logic               timer_active;
    logic [BUF_W-1:0]   occ_q;
    logic               bufs_full;
    logic [BTIME_W-1:0] btime_q;

    assign evt.trig   = l0_trig_i;
    assign evt.retire = evt_retire_i;

    tbg_regs #(.DEF_HOLD(DEF_HOLD), .DEF_BUFS(DEF_BUFS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en_i),
        .rd_en (reg_rd_en_i),
        .addr  (reg_addr_i),
        .wdata (reg_wdata_i),
        .btime (btime_q),
        .cfg   (cfg),
        .rdata (reg_rdata_o)
    );

    tbg_hold_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .trig    (l0_trig_i),
        .hold    (cfg.hold),
        .timer_q (timer_q),
        .active  (timer_active)
    );

    tbg_occupancy u_occ (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .limit (cfg.bufs),
        .occ_q (occ_q),
        .full  (bufs_full)
    );

    assign busy_o = timer_active | bufs_full;

    tbg_busy_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy_o),
        .btime_q (btime_q)
    );
endmodule

// File: rtl/tbg_checker.sv
module tbg_checker
    import tbg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               l0,
    input logic               retire,
    input logic               busy,
    input logic [HOLD_W-1:0]  hold,
    input logic [HOLD_W-1:0]  timer,
    input logic [BUF_W-1:0]   occ,
    input logic [BUF_W-1:0]   bufs,
    input logic [BTIME_W-1:0] btime
);
    a_r1_trig_busy: assert property (@(posedge clk) disable iff (rst)
        (l0 && hold != '0) |=> busy);

    a_r2_reload: assert property (@(posedge clk) disable iff (rst)
        l0 |=> (timer == $past(hold)));

    a_r3_sat_top: assert property (@(posedge clk) disable iff (rst)
        (l0 && !retire && occ >= bufs) |=> (occ == $past(occ)));

    a_r3_sat_zero: assert property (@(posedge clk) disable iff (rst)
        (retire && !l0 && occ == '0) |=> (occ == '0));

    a_r3_cancel: assert property (@(posedge clk) disable iff (rst)
        (retire && l0) |=> $stable(occ));

    a_r4_full_busy: assert property (@(posedge clk) disable iff (rst)
        (occ >= bufs) |-> busy);

    a_r6_count_up: assert property (@(posedge clk) disable iff (rst)
        busy |=> (btime == $past(btime) + BTIME_W'(1)));

    a_r6_count_hold: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(btime));
endmodule

bind trig_busy_gen tbg_checker u_tbg_checker (
    .clk    (clk),
    .rst    (rst),
    .l0     (l0_trig_i),
    .retire (evt_retire_i),
    .busy   (busy_o),
    .hold   (cfg.hold),
    .timer  (timer_q),
    .occ    (occ_q),
    .bufs   (cfg.bufs),
    .btime  (btime_q)
);

// File: tb/tb_trig_busy_gen.sv
`timescale 1ns/1ps
module tb_trig_busy_gen;
    localparam logic [15:0] D_HOLD = 16'd8;
    localparam logic [15:0] D_BUFS = 16'd4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        l0 = 1'b0, ret = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic        busy;
    logic [15:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] mhold, mbufs, mtimer, mocc, mlatch;
    logic [31:0] mcount;

    always #10 clk = ~clk;

    trig_busy_gen #(.DEF_HOLD(D_HOLD), .DEF_BUFS(D_BUFS)) dut (
        .clk(clk), .rst(rst), .l0_trig_i(l0), .evt_retire_i(ret), .busy_o(busy),
        .reg_wr_en_i(wr), .reg_rd_en_i(rd), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata)
    );

    function automatic logic model_busy();
        return (mtimer != 16'd0) || (mocc >= mbufs);
    endfunction

    function automatic logic [15:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return mhold;
            2'd1:    return mbufs;
            2'd2:    return mlatch;
            default: return mcount[15:0];
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic t, input logic r, input logic we, input logic re,
                        input logic [1:0] a, input logic [15:0] wd, input string req);
        logic bpre;
        @(negedge clk);
        l0 = t; ret = r; wr = we; rd = re; addr = a; wdata = wd;
        #1;
        if (re) chk({req, " read"}, {16'd0, rdata}, {16'd0, model_read(a)});
        bpre = model_busy();
        if (re && a == 2'd3) mlatch = mcount[31:16];
        mcount = mcount + {31'd0, bpre};
        if (t) mtimer = mhold;
        else if (mtimer != 16'd0) mtimer = mtimer - 16'd1;
        if (t && !r && mocc < mbufs) mocc = mocc + 16'd1;
        else if (r && !t && mocc != 16'd0) mocc = mocc - 16'd1;
        if (we && a == 2'd0) mhold = wd;
        if (we && a == 2'd1) mbufs = wd;
        @(posedge clk);
        #1;
        chk({req, " busy"}, {31'd0, busy}, {31'd0, model_busy()});
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 2'd0, 16'd0, req);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [15:0] v, input string req);
        step(0, 0, 1, 0, a, v, req);
    endtask

    task automatic rreg(input logic [1:0] a, input string req);
        step(0, 0, 0, 1, a, 16'd0, req);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        mhold = D_HOLD; mbufs = D_BUFS; mtimer = 0; mocc = 0; mlatch = 0; mcount = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R8 reset busy", {31'd0, busy}, 32'd0);
        rreg(2'd3, "R8");
        rreg(2'd2, "R8");
        rreg(2'd0, "R5");
        rreg(2'd1, "R5");

        // R5: writes and read-back
        wreg(2'd0, 16'd5, "R5");
        wreg(2'd1, 16'd100, "R5");
        rreg(2'd0, "R5");
        rreg(2'd1, "R5");

        // R1: single trigger, exact hold window
        step(1, 0, 0, 0, 2'd0, 16'd0, "R1");
        idle(8, "R1");
        // R2: retrigger mid-hold
        step(1, 0, 0, 0, 2'd0, 16'd0, "R2");
        idle(2, "R2");
        step(1, 0, 0, 0, 2'd0, 16'd0, "R2");
        idle(7, "R2");
        // R1: zero hold
        wreg(2'd0, 16'd0, "R1");
        step(1, 0, 0, 0, 2'd0, 16'd0, "R1");
        idle(2, "R1");

        // R3/R4: saturation at top and bottom
        wreg(2'd1, 16'd2, "R4");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 2'd0, 16'd0, "R3 top");
        idle(2, "R4 full");
        step(0, 1, 0, 0, 2'd0, 16'd0, "R3 top release");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 2'd0, 16'd0, "R3 zero");
        step(1, 1, 0, 0, 2'd0, 16'd0, "R3 cancel");
        step(1, 0, 0, 0, 2'd0, 16'd0, "R3");
        step(1, 1, 0, 0, 2'd0, 16'd0, "R3 cancel");
        step(1, 0, 0, 0, 2'd0, 16'd0, "R4 full again");
        idle(2, "R4");
        step(0, 1, 0, 0, 2'd0, 16'd0, "R4");
        step(0, 1, 0, 0, 2'd0, 16'd0, "R4");
        // R4: zero buffers keeps busy
        wreg(2'd1, 16'd0, "R4 zero bufs");
        idle(5, "R4 zero bufs");

        // R6/R7: run accumulator past 2^16, capture, run again, read upper
        idle(66000, "R6");
        rreg(2'd3, "R7 lo");
        idle(66000, "R6");
        rreg(2'd2, "R7 hi captured");
        rreg(2'd3, "R7 lo live");
        rreg(2'd2, "R7 hi recaptured");
        wreg(2'd1, 16'd3, "R5");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic t, r, we, re;
            logic [1:0] a;
            logic [15:0] v;
            t  = ($urandom_range(0, 3) == 0);
            r  = ($urandom_range(0, 3) == 0);
            we = ($urandom_range(0, 39) == 0);
            re = ($urandom_range(0, 4) == 0);
            a  = 2'($urandom_range(0, 3));
            v  = (a == 2'd0) ? 16'($urandom_range(0, 12)) : 16'($urandom_range(0, 5));
            if (we && a[1]) we = 1'b0;
            step(t, r, we, re, a, v, "R3 R4 R6 random");
        end
        rreg(2'd3, "R7");
        rreg(2'd2, "R7");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(190000 * 20);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule